// File: doc/BRIEF.md
# Powered-Ethernet Port Sequencer (quad)

This block steps each of four powered-Ethernet ports through signature detection, classification and power application, then watches the powered port for sustained overcurrent or a lost load. The analog side is abstracted to per-port flags: a detection verdict, a three-bit class result, an overcurrent flag and a disconnect flag. The block answers with a gate-enable per port, a state code, the latched detection and class results, and one-cycle event pulses that an interrupt block can collect.

A packed mode register holds two bits per port, and those bits decide how far each port advances without the host. In manual mode a port does nothing until the host commands a detection or classification cycle, and it stops again after that cycle. In semiauto mode the port detects and classifies on its own and then waits for a host power-on. In auto mode a good detection runs on into classification, a turn-on delay and power. In shutdown mode the port stays off. All timing windows count ticks of a prescaled system clock.

The per-port machine has six states. IDLE is off and waiting. DETECT and CLASSIFY each run a measurement window. HOLD waits for the host. DELAY is the turn-on delay in auto mode. ON drives the gate. The transitions are as follows. IDLE goes to DETECT on a host command in manual mode and by itself in the other modes. IDLE goes to CLASSIFY on a host command in manual mode. IDLE goes to ON on a host power-on in manual or semiauto mode. DETECT goes to HOLD in manual mode, to CLASSIFY on a good result and back to IDLE on a bad one. CLASSIFY goes to DELAY in auto mode and to HOLD otherwise. HOLD goes to DETECT, CLASSIFY or ON on the matching host command, and to IDLE if the mode becomes auto. DELAY goes to ON. ON goes to IDLE on a fault or a disconnect. Any state goes to IDLE on power-off or in shutdown mode.

Top module: `poe_quad_seq`

## Requirements
- R1: While `rst_n` is low, every port is forced to IDLE (state code 0) with its gate off, its events clear and its latched results at 0. Every two-bit mode field loads `auto_strap` replicated, so the fields read 11 when the strap is 1 and 00 when it is 0.
- R2: Mode 00 (shutdown) holds the port in IDLE with its gate off from the next clock and ignores every host command. Entering shutdown while powered turns the port off.
- R3: In mode 01 (manual) a port leaves IDLE only on a host command. When a detection cycle ends, it waits in HOLD (code 3) and does not classify until commanded.
- R4: A detection window lasts DET_TICKS prescaled ticks in state DETECT (code 1). At its end the detection verdict is latched on `det_ok` and `ev_det` pulses for one cycle.
- R5: A classification window lasts CLS_TICKS ticks in state CLASSIFY (code 2). At its end the class input is latched on `cls_val` and `ev_cls` pulses for one cycle.
- R6: In mode 11 (auto) a good detection runs into classification, then DELAY (code 4) for TON_TICKS ticks, then ON (code 5) with the gate driven. A bad detection returns to IDLE and detection is retried.
- R7: In mode 10 (semiauto) detection and classification run unprompted. The port then waits in HOLD with the gate off until a host power-on.
- R8: A powered port goes to IDLE and pulses `ev_disc` once the disconnect flag has stayed high for DIS_TICKS ticks. A shorter assertion leaves the port on.
- R9: A powered port goes to IDLE and pulses `ev_fault` once the overcurrent flag has stayed high for OC_TICKS ticks. If both windows expire together, the fault is the one reported.
- R10: A host power-off forces the port to IDLE with its gate off on the next clock, in any mode and any state.
- R11: The ports are independent. Port p uses mode bits [2p+1:2p], state code bits [3p+2:3p] and class bits [3p+2:3p]. A mode field changes only on a write strobe.
- R12: A host power-on is accepted only in IDLE or HOLD and only in manual or semiauto mode. In auto mode it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| auto_strap | input | 1 | Level loaded into every mode bit during reset |
| mode_wr | input | 1 | Write strobe for the packed mode register |
| mode_wdata | input | 2*NPORTS | New packed mode fields |
| cmd_det | input | NPORTS | Per-port restart-detection command pulse |
| cmd_cls | input | NPORTS | Per-port restart-classification command pulse |
| cmd_pon | input | NPORTS | Per-port power-on command pulse |
| cmd_poff | input | NPORTS | Per-port power-off command pulse |
| fe_det_good | input | NPORTS | Front-end verdict: valid signature present |
| fe_cls_code | input | 3*NPORTS | Front-end class result, three bits per port |
| fe_oc | input | NPORTS | Front-end overcurrent flag |
| fe_disc | input | NPORTS | Front-end disconnect flag (AC or DC sensing) |
| mode_q | output | 2*NPORTS | Current packed mode register |
| gate_en | output | NPORTS | Gate drive enable per port |
| port_state | output | 3*NPORTS | State code per port |
| det_ok | output | NPORTS | Latched detection verdict |
| cls_val | output | 3*NPORTS | Latched class result |
| ev_det | output | NPORTS | Detection-complete pulse |
| ev_cls | output | NPORTS | Classification-complete pulse |
| ev_fault | output | NPORTS | Overcurrent shut-off pulse |
| ev_disc | output | NPORTS | Disconnect shut-off pulse |

## Verification
The bench builds the block with a prescale of 3 and windows of 4 (detection), 3 (classification), 5 (turn-on), 6 (overcurrent) and 4 (disconnect) ticks. With these values a full auto power-up takes a few dozen cycles, so one short run covers every mode on four ports side by side. The run also includes sub-window disconnect glitches, fault timeouts, and power-off and shutdown applied while a port is powered. Because the prescale is small and not a power of two, the start of each window falls at different phases of the tick. This exercises the rule that a window counts only whole ticks taken after the state is entered.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    typedef enum logic [1:0] {
        MD_SHUT = 2'b00,
        MD_MAN  = 2'b01,
        MD_SEMI = 2'b10,
        MD_AUTO = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DETECT = 3'd1,
        ST_CLASS  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DELAY  = 3'd4,
        ST_ON     = 3'd5
    } pstate_e;

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/poe_tick_gen.sv
module poe_tick_gen #(
    parameter int unsigned PRESCALE = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = poe_seq_pkg::bits_for(PRESCALE);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CW'(PRESCALE - 1)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4

endmodule

// File: rtl/poe_win_timer.sv
module poe_win_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr || !run)       cnt_q <= '0;
        else if (tick && cnt_q != lim) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == lim);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !tick) |=> (cnt_q == $past(cnt_q))); // R8

endmodule

// File: rtl/poe_port_fsm.sv
module poe_port_fsm
    import poe_seq_pkg::*;
#(
    parameter int unsigned TW        = 8,
    parameter int unsigned DET_TICKS = 4,
    parameter int unsigned CLS_TICKS = 3,
    parameter int unsigned TON_TICKS = 5,
    parameter int unsigned OC_TICKS  = 6,
    parameter int unsigned DIS_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] mode,
    input  logic       c_det,
    input  logic       c_cls,
    input  logic       c_pon,
    input  logic       c_poff,
    input  logic       fe_good,
    input  logic [2:0] fe_cls,
    input  logic       fe_oc,
    input  logic       fe_disc,
    output logic       gate,
    output logic [2:0] st_code,
    output logic       det_ok,
    output logic [2:0] cls_val,
    output logic       ev_det,
    output logic       ev_cls,
    output logic       ev_flt,
    output logic       ev_dis
);
    pstate_e st_q, st_d;
    mode_e   md;
    logic    det_q, det_d;
    logic [2:0] cls_q, cls_d;
    logic    e_det, e_cls, e_flt, e_dis;
    logic    ev_det_q, ev_cls_q, ev_flt_q, ev_dis_q;
    logic    st_chg;
    logic    ph_run, ph_done, oc_run, oc_done, dx_run, dx_done;
    logic [TW-1:0] ph_lim;

    assign md     = mode_e'(mode);
    assign st_chg = (st_d != st_q);
    assign ph_run = (st_q == ST_DETECT) || (st_q == ST_CLASS) || (st_q == ST_DELAY);
    assign oc_run = (st_q == ST_ON) && fe_oc;
    assign dx_run = (st_q == ST_ON) && fe_disc;

    always_comb begin
        case (st_q)
            ST_DETECT: ph_lim = TW'(DET_TICKS);
            ST_CLASS:  ph_lim = TW'(CLS_TICKS);
            default:   ph_lim = TW'(TON_TICKS);
        endcase
    end

    poe_win_timer #(.W(TW)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(ph_run), .clr(st_chg),
        .lim(ph_lim), .done(ph_done)
    );

    poe_win_timer #(.W(TW)) u_oc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(oc_run), .clr(st_chg),
        .lim(TW'(OC_TICKS)), .done(oc_done)
    );

    poe_win_timer #(.W(TW)) u_disc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(dx_run), .clr(st_chg),
        .lim(TW'(DIS_TICKS)), .done(dx_done)
    );

    // next-state and event decode
    always_comb begin
        st_d  = st_q;
        det_d = det_q;
        cls_d = cls_q;
        e_det = 1'b0;
        e_cls = 1'b0;
        e_flt = 1'b0;
        e_dis = 1'b0;
        if (md == MD_SHUT) begin
            st_d = ST_IDLE;
        end else if (c_poff) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (c_pon && md != MD_AUTO)  st_d = ST_ON;
                    else if (md == MD_MAN) begin
                        if (c_det)      st_d = ST_DETECT;
                        else if (c_cls) st_d = ST_CLASS;
                    end else            st_d = ST_DETECT;
                end
                ST_DETECT: begin
                    if (ph_done) begin
                        e_det = 1'b1;
                        det_d = fe_good;
                        if (md == MD_MAN)  st_d = ST_HOLD;
                        else if (fe_good)  st_d = ST_CLASS;
                        else               st_d = ST_IDLE;
                    end
                end
                ST_CLASS: begin
                    if (ph_done) begin
                        e_cls = 1'b1;
                        cls_d = fe_cls;
                        st_d  = (md == MD_AUTO) ? ST_DELAY : ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (md == MD_AUTO) st_d = ST_IDLE;
                    else if (c_pon)    st_d = ST_ON;
                    else if (c_det)    st_d = ST_DETECT;
                    else if (c_cls)    st_d = ST_CLASS;
                end
                ST_DELAY: begin
                    if (ph_done) st_d = ST_ON;
                end
                ST_ON: begin
                    if (oc_done) begin
                        e_flt = 1'b1;
                        st_d  = ST_IDLE;
                    end else if (dx_done) begin
                        e_dis = 1'b1;
                        st_d  = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            det_q    <= 1'b0;
            cls_q    <= 3'd0;
            ev_det_q <= 1'b0;
            ev_cls_q <= 1'b0;
            ev_flt_q <= 1'b0;
            ev_dis_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            det_q    <= det_d;
            cls_q    <= cls_d;
            ev_det_q <= e_det;
            ev_cls_q <= e_cls;
            ev_flt_q <= e_flt;
            ev_dis_q <= e_dis;
        end
    end

    // outputs
    always_comb begin
        gate    = (st_q == ST_ON);
        st_code = st_q;
        det_ok  = det_q;
        cls_val = cls_q;
        ev_det  = ev_det_q;
        ev_cls  = ev_cls_q;
        ev_flt  = ev_flt_q;
        ev_dis  = ev_dis_q;
    end

    AST_SHUT_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_SHUT) |=> (st_q == ST_IDLE)); // R2
    AST_POFF_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        c_poff |=> (st_q == ST_IDLE)); // R10
    AST_DET_EV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_det_q |-> ($past(st_q) == ST_DETECT)); // R4
    AST_CLS_EV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cls_q |-> ($past(st_q) == ST_CLASS)); // R5
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flt_q |-> (st_q == ST_IDLE && $past(fe_oc))); // R9
    AST_DISC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dis_q |-> (st_q == ST_IDLE && $past(fe_disc))); // R8
    AST_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ON && $past(st_q) != ST_ON) |->
        ($past(st_q) == ST_DELAY || ($past(c_pon) && $past(md) != MD_AUTO))); // R12

endmodule

// File: rtl/poe_quad_seq.sv
module poe_quad_seq
    import poe_seq_pkg::*;
#(
    parameter int unsigned NPORTS    = 4,
    parameter int unsigned PRESCALE  = 1000,
    parameter int unsigned DET_TICKS = 170,
    parameter int unsigned CLS_TICKS = 12,
    parameter int unsigned TON_TICKS = 60,
    parameter int unsigned OC_TICKS  = 60,
    parameter int unsigned DIS_TICKS = 350
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  auto_strap,
    input  logic                  mode_wr,
    input  logic [2*NPORTS-1:0]   mode_wdata,
    input  logic [NPORTS-1:0]     cmd_det,
    input  logic [NPORTS-1:0]     cmd_cls,
    input  logic [NPORTS-1:0]     cmd_pon,
    input  logic [NPORTS-1:0]     cmd_poff,
    input  logic [NPORTS-1:0]     fe_det_good,
    input  logic [3*NPORTS-1:0]   fe_cls_code,
    input  logic [NPORTS-1:0]     fe_oc,
    input  logic [NPORTS-1:0]     fe_disc,
    output logic [2*NPORTS-1:0]   mode_q,
    output logic [NPORTS-1:0]     gate_en,
    output logic [3*NPORTS-1:0]   port_state,
    output logic [NPORTS-1:0]     det_ok,
    output logic [3*NPORTS-1:0]   cls_val,
    output logic [NPORTS-1:0]     ev_det,
    output logic [NPORTS-1:0]     ev_cls,
    output logic [NPORTS-1:0]     ev_fault,
    output logic [NPORTS-1:0]     ev_disc
);
    localparam int unsigned TMAX = max2(max2(max2(DET_TICKS, CLS_TICKS), max2(TON_TICKS, OC_TICKS)), DIS_TICKS);
    localparam int unsigned TW   = bits_for(TMAX);
    localparam int unsigned MW   = 2 * NPORTS;

    logic tick;

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= {MW{auto_strap}};
        else if (mode_wr) mode_q <= mode_wdata;
    end

    poe_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        poe_port_fsm #(
            .TW(TW), .DET_TICKS(DET_TICKS), .CLS_TICKS(CLS_TICKS),
            .TON_TICKS(TON_TICKS), .OC_TICKS(OC_TICKS), .DIS_TICKS(DIS_TICKS)
        ) u_fsm (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .mode(mode_q[2*p +: 2]),
            .c_det(cmd_det[p]), .c_cls(cmd_cls[p]),
            .c_pon(cmd_pon[p]), .c_poff(cmd_poff[p]),
            .fe_good(fe_det_good[p]), .fe_cls(fe_cls_code[3*p +: 3]),
            .fe_oc(fe_oc[p]), .fe_disc(fe_disc[p]),
            .gate(gate_en[p]), .st_code(port_state[3*p +: 3]),
            .det_ok(det_ok[p]), .cls_val(cls_val[3*p +: 3]),
            .ev_det(ev_det[p]), .ev_cls(ev_cls[p]),
            .ev_flt(ev_fault[p]), .ev_dis(ev_disc[p])
        );
    end

    AST_MODE_STRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode_q == {MW{$past(auto_strap)}})); // R1
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q)); // R11

endmodule

// File: tb/poe_quad_seq_test.sv
`timescale 1ns/100ps
module poe_quad_seq_test;
    localparam int N = 4, P = 3, DT = 4, CT = 3, TT = 5, OT = 6, XT = 4;

    logic clk = 1'b0, rst_n = 1'b0, auto_strap = 1'b0, mode_wr = 1'b0;
    logic [2*N-1:0] mode_wdata = '0;
    logic [N-1:0] cmd_det = '0, cmd_cls = '0, cmd_pon = '0, cmd_poff = '0;
    logic [N-1:0] fe_det_good = '0, fe_oc = '0, fe_disc = '0;
    logic [3*N-1:0] fe_cls_code = '0;
    logic [2*N-1:0] mode_q;
    logic [N-1:0] gate_en, det_ok, ev_det, ev_cls, ev_fault, ev_disc;
    logic [3*N-1:0] port_state, cls_val;

    poe_quad_seq #(.NPORTS(N), .PRESCALE(P), .DET_TICKS(DT), .CLS_TICKS(CT),
                   .TON_TICKS(TT), .OC_TICKS(OT), .DIS_TICKS(XT)) uut (
        .clk(clk), .rst_n(rst_n), .auto_strap(auto_strap), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .cmd_det(cmd_det), .cmd_cls(cmd_cls),
        .cmd_pon(cmd_pon), .cmd_poff(cmd_poff), .fe_det_good(fe_det_good),
        .fe_cls_code(fe_cls_code), .fe_oc(fe_oc), .fe_disc(fe_disc),
        .mode_q(mode_q), .gate_en(gate_en), .port_state(port_state),
        .det_ok(det_ok), .cls_val(cls_val), .ev_det(ev_det), .ev_cls(ev_cls),
        .ev_fault(ev_fault), .ev_disc(ev_disc));

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    logic [N-1:0] seen_det = '0, seen_flt = '0, seen_dis = '0;

    // behavioural reference model
    int m_pc;
    int m_st[N], m_ph[N], m_oc[N], m_dx[N], m_det[N], m_cls[N], m_mode[N];
    bit [3:0] m_ev[N];
    bit m_tk;

    task automatic step_port(input int i, input bit tk);
        int st, nx, md, lim;
        bit pd, od, dd, timed;
        bit [3:0] ev;
        st = m_st[i]; md = m_mode[i]; nx = st; ev = '0;
        timed = (st == 1 || st == 2 || st == 4);
        lim = (st == 1) ? DT : (st == 2) ? CT : TT;
        pd = timed && m_ph[i] == lim;
        od = st == 5 && fe_oc[i] && m_oc[i] == OT;
        dd = st == 5 && fe_disc[i] && m_dx[i] == XT;
        if (md == 0) nx = 0;
        else if (cmd_poff[i]) nx = 0;
        else case (st)
            0: if (cmd_pon[i] && md != 3) nx = 5;
               else if (md == 1) begin
                   if (cmd_det[i]) nx = 1; else if (cmd_cls[i]) nx = 2;
               end else nx = 1;
            1: if (pd) begin
                   ev[0] = 1'b1; m_det[i] = fe_det_good[i];
                   nx = (md == 1) ? 3 : (fe_det_good[i] ? 2 : 0);
               end
            2: if (pd) begin
                   ev[1] = 1'b1; m_cls[i] = fe_cls_code[3*i +: 3];
                   nx = (md == 3) ? 4 : 3;
               end
            3: if (md == 3) nx = 0;
               else if (cmd_pon[i]) nx = 5;
               else if (cmd_det[i]) nx = 1;
               else if (cmd_cls[i]) nx = 2;
            4: if (pd) nx = 5;
            5: if (od) begin ev[2] = 1'b1; nx = 0; end
               else if (dd) begin ev[3] = 1'b1; nx = 0; end
            default: nx = 0;
        endcase
        if (nx != st || !timed) m_ph[i] = 0;
        else if (tk && m_ph[i] != lim) m_ph[i]++;
        if (nx != st || !(st == 5 && fe_oc[i])) m_oc[i] = 0;
        else if (tk && m_oc[i] != OT) m_oc[i]++;
        if (nx != st || !(st == 5 && fe_disc[i])) m_dx[i] = 0;
        else if (tk && m_dx[i] != XT) m_dx[i]++;
        m_st[i] = nx; m_ev[i] = ev;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0;
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_ph[i] = 0; m_oc[i] = 0; m_dx[i] = 0;
                m_det[i] = 0; m_cls[i] = 0; m_ev[i] = '0;
                m_mode[i] = auto_strap ? 3 : 0;
            end
        end else begin
            m_tk = (m_pc == P - 1);
            m_pc = m_tk ? 0 : m_pc + 1;
            for (int i = 0; i < N; i++) step_port(i, m_tk);
            if (mode_wr) for (int i = 0; i < N; i++) m_mode[i] = int'(mode_wdata[2*i +: 2]);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            seen_det = seen_det | ev_det;
            seen_flt = seen_flt | ev_fault;
            seen_dis = seen_dis | ev_disc;
            for (int i = 0; i < N; i++) begin
                checks++;
                if (int'(port_state[3*i +: 3]) != m_st[i] || gate_en[i] != (m_st[i] == 5) ||
                    int'(det_ok[i]) != m_det[i] || int'(cls_val[3*i +: 3]) != m_cls[i] ||
                    {ev_disc[i], ev_fault[i], ev_cls[i], ev_det[i]} != m_ev[i] ||
                    int'(mode_q[2*i +: 2]) != m_mode[i]) begin
                    errors++;
                    $display("FAIL R11 model port %0d: state %0d exp %0d gate %0b ev %b exp %b cls %0d exp %0d",
                             i, port_state[3*i +: 3], m_st[i], gate_en[i],
                             {ev_disc[i], ev_fault[i], ev_cls[i], ev_det[i]}, m_ev[i],
                             cls_val[3*i +: 3], m_cls[i]);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0; auto_strap = strap;
        cyc(3);
        rst_n = 1'b1;
    endtask

    function automatic int pst(input int i);
        return int'(port_state[3*i +: 3]);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        chk(mode_q == '0, "R1 strap low mode", int'(mode_q), 0);
        chk(gate_en == '0, "R1 gates off", int'(gate_en), 0);
        chk(port_state == '0, "R1 idle", int'(port_state), 0);
        chk(cls_val == '0 && det_ok == '0, "R1 latched clear", int'(cls_val), 0);

        fe_det_good = '1;
        fe_cls_code = {3'd4, 3'd2, 3'd1, 3'd3};
        cmd_det = '1; cyc(1); cmd_det = '0;
        cmd_pon = '1; cyc(1); cmd_pon = '0;
        cyc(40);
        chk(port_state == '0 && gate_en == '0, "R2 shutdown ignores commands", int'(port_state), 0);

        // port3 shutdown, port2 manual, port1 semiauto, port0 auto
        mode_wdata = {2'b00, 2'b01, 2'b10, 2'b11}; mode_wr = 1'b1; cyc(1); mode_wr = 1'b0;
        chk(mode_q[1:0] == 2'b11 && mode_q[7:6] == 2'b00, "R11 mode fields", int'(mode_q), 8'h1B);
        cyc(80);
        chk(gate_en[0] == 1'b1 && pst(0) == 5, "R6 auto powers on", pst(0), 5);
        chk(int'(cls_val[2:0]) == 3, "R5 auto class latched", int'(cls_val[2:0]), 3);
        chk(pst(1) == 3 && gate_en[1] == 1'b0, "R7 semiauto waits in HOLD", pst(1), 3);
        chk(det_ok[1] == 1'b1, "R4 semiauto detect latched", int'(det_ok[1]), 1);
        chk(pst(2) == 0, "R3 manual stays idle", pst(2), 0);
        chk(pst(3) == 0 && gate_en[3] == 1'b0, "R2 shutdown port off", pst(3), 0);

        cmd_det[2] = 1'b1; cyc(1); cmd_det[2] = 1'b0;
        cyc(25);
        chk(pst(2) == 3, "R3 manual holds after detect", pst(2), 3);
        chk(det_ok[2] == 1'b1 && seen_det[2], "R4 manual detect event", int'(seen_det[2]), 1);
        cyc(30);
        chk(pst(2) == 3 && int'(cls_val[8:6]) == 0, "R3 manual no auto classify", pst(2), 3);
        cmd_cls[2] = 1'b1; cyc(1); cmd_cls[2] = 1'b0;
        cyc(20);
        chk(int'(cls_val[8:6]) == 2 && pst(2) == 3, "R5 manual class latched", int'(cls_val[8:6]), 2);

        cmd_pon = 4'b0110; cyc(1); cmd_pon = '0;
        cyc(2);
        chk(gate_en[2:1] == 2'b11, "R12 power-on accepted semi/manual", int'(gate_en[2:1]), 3);

        fe_disc[1] = 1'b1; cyc(6); fe_disc[1] = 1'b0;
        cyc(4);
        chk(gate_en[1] == 1'b1 && !seen_dis[1], "R8 short disconnect ignored", int'(gate_en[1]), 1);
        fe_disc[1] = 1'b1; cyc(30); fe_disc[1] = 1'b0;
        chk(seen_dis[1] && pst(1) != 5, "R8 disconnect turns off", pst(1), 0);

        fe_oc[2] = 1'b1; cyc(30); fe_oc[2] = 1'b0;
        chk(seen_flt[2] && gate_en[2] == 1'b0, "R9 overcurrent fault", int'(gate_en[2]), 0);

        cmd_poff[0] = 1'b1; cyc(1); cmd_poff[0] = 1'b0;
        chk(pst(0) == 0 && gate_en[0] == 1'b0, "R10 power-off in auto", pst(0), 0);

        fe_det_good[0] = 1'b0; cyc(40);
        cmd_pon[0] = 1'b1; cyc(1); cmd_pon[0] = 1'b0;
        cyc(3);
        chk(gate_en[0] == 1'b0, "R12 auto ignores power-on", int'(gate_en[0]), 0);
        chk(pst(0) != 5 && det_ok[0] == 1'b0, "R6 bad detect retried", int'(det_ok[0]), 0);

        cyc(40);
        chk(pst(1) == 3, "R7 semiauto back in HOLD", pst(1), 3);
        cmd_pon[1] = 1'b1; cyc(1); cmd_pon[1] = 1'b0;
        chk(gate_en[1] == 1'b1, "R7 semiauto powered by host", int'(gate_en[1]), 1);
        mode_wdata = {2'b00, 2'b01, 2'b00, 2'b11}; mode_wr = 1'b1; cyc(1); mode_wr = 1'b0;
        cyc(1);
        chk(pst(1) == 0 && gate_en[1] == 1'b0, "R2 shutdown turns powered port off", pst(1), 0);

        do_reset(1'b1);
        chk(mode_q == '1, "R1 strap high mode", int'(mode_q), 255);
        chk(gate_en == '0 && port_state == '0, "R1 reset turns ports off", int'(gate_en), 0);
        cyc(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule